// File: doc/BRIEF.md
# Shift and Rotate Unit with Auxiliary MQ Register

This block is a combinational shifter for a 32-bit datapath that also owns one registered auxiliary word, called MQ here. For each operation it takes an operand, a 6-bit shift amount and an operation code. It returns a result at once and shows the value that MQ will hold after the next clock edge. The low five bits of the amount give the shift distance n. Bit 5 is used only by the masked forms: it inverts the mask, and in one right form it forces a result of all ones.

Left forms place the operand rotated left by n into MQ. Right forms place it rotated right by n. Some forms merge earlier MQ contents into the result under a mask built from the amount, so a long shift can be spread across two operations. The instruction decoder drives the operation code and a valid strobe. MQ changes only on a valid operation that writes it.

Top module: `mq_shift_unit`

## Requirements
- R1: An active-low reset clears MQ to zero.
- R2: MQ takes the value of `mq_next` at a rising clock edge only when `op_valid` is high and the selected operation writes MQ. At all other times `mq_next` equals MQ and MQ keeps its value. Every operation except code 2 writes MQ.
- R3: The operation codes are 0 SLE, 1 SLEQ, 2 SLLQ, 3 SLQ, 4 SRAQ, 5 SRE, 6 SREA, 7 SREQ, 8 SRLQ and 9 SRQ. Codes 10 to 15 give a result of zero and leave MQ unchanged.
- R4: SLE (0) gives the operand shifted left by n and writes MQ with the operand rotated left by n. Bit 5 of the amount is ignored.
- R5: SLEQ (1) works like SLE, and also ORs old MQ shifted right by 32−n into the result. When n is 0 that term is zero.
- R6: The left mask is all ones shifted left by n, inverted when amount bit 5 is set. SLLQ (2) takes the operand shifted left by n where the mask is one, and old MQ where the mask is zero.
- R7: SLQ (3) gives the operand rotated left by n ANDed with the left mask, and writes MQ with the full rotated operand.
- R8: Every right form (4 to 9) except SREA writes MQ with the operand rotated right by n. Rotating by 32 counts as rotating by 0.
- R9: SRAQ (4) gives all ones when amount bit 5 is set. Otherwise it gives the operand shifted right arithmetically by n.
- R10: SRE (5) gives the arithmetic right shift by n. SRQ (9) gives the logical right shift by n.
- R11: SREA (6) gives the arithmetic right shift by n and writes MQ with the logical right shift by n.
- R12: SREQ (7) gives the logical right shift by n ORed with old MQ ANDed with the sign mask. The sign mask is bit 31 alone, shifted right arithmetically by n.
- R13: SRLQ (8) uses the sign mask, inverted when amount bit 5 is set. It gives the logical right shift by n where the mask is one, and old MQ where the mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code |
| operand | input | 32 | Value to shift |
| amount | input | 6 | Shift amount; bit 5 is the mask/overflow bit |
| result | output | 32 | Shifted result |
| mq_next | output | 32 | Value MQ will hold after the next edge |
| mq | output | 32 | Current MQ contents |

## Verification
The assertions assume that `op_sel` and `amount` are stable and known whenever `op_valid` is high, and that reset is held for at least one edge. The bench changes inputs only on falling edges and always drives defined codes. Before each vector it loads MQ with a known word through an SLE by zero. This means every merge and mask case sees fixed old MQ contents, and the expected values do not depend on earlier vectors.

// File: rtl/mq_shift_unit.sv
module mq_shift_unit #(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [3:0]            op_sel,
  input  logic [W-1:0]          operand,
  input  logic [$clog2(W):0]    amount,
  output logic [W-1:0]          result,
  output logic [W-1:0]          mq_next,
  output logic [W-1:0]          mq
);
  localparam int SW = $clog2(W);

  localparam logic [3:0] OP_SLE  = 4'd0;
  localparam logic [3:0] OP_SLEQ = 4'd1;
  localparam logic [3:0] OP_SLLQ = 4'd2;
  localparam logic [3:0] OP_SLQ  = 4'd3;
  localparam logic [3:0] OP_SRAQ = 4'd4;
  localparam logic [3:0] OP_SRE  = 4'd5;
  localparam logic [3:0] OP_SREA = 4'd6;
  localparam logic [3:0] OP_SREQ = 4'd7;
  localparam logic [3:0] OP_SRLQ = 4'd8;
  localparam logic [3:0] OP_SRQ  = 4'd9;

  logic [SW-1:0] n;
  logic          hi;
  logic [W-1:0]  rol, ror, shl, shr, sra;
  logic [W-1:0]  lmsk, smsk, rmsk;
  logic [W-1:0]  mq_new;
  logic          wr;

  assign n  = amount[SW-1:0];
  assign hi = amount[SW];

  assign shl = operand << n;
  assign shr = operand >> n;
  assign sra = $signed(operand) >>> n;
  assign rol = shl | (operand >> (W - int'(n)));
  assign ror = shr | (operand << (W - int'(n)));

  assign lmsk = hi ? ~({W{1'b1}} << n) : ({W{1'b1}} << n);
  assign smsk = $signed({1'b1, {(W-1){1'b0}}}) >>> n;
  assign rmsk = hi ? ~smsk : smsk;

  always_comb begin
    result = '0;
    mq_new = mq;
    wr     = 1'b1;
    case (op_sel)
      OP_SLE:  begin result = shl;                            mq_new = rol; end
      OP_SLEQ: begin result = shl | (mq >> (W - int'(n)));    mq_new = rol; end
      OP_SLLQ: begin result = (shl & lmsk) | (mq & ~lmsk);    wr = 1'b0;    end
      OP_SLQ:  begin result = rol & lmsk;                     mq_new = rol; end
      OP_SRAQ: begin result = hi ? {W{1'b1}} : sra;           mq_new = ror; end
      OP_SRE:  begin result = sra;                            mq_new = ror; end
      OP_SREA: begin result = sra;                            mq_new = shr; end
      OP_SREQ: begin result = shr | (mq & smsk);              mq_new = ror; end
      OP_SRLQ: begin result = (shr & rmsk) | (mq & ~rmsk);    mq_new = ror; end
      OP_SRQ:  begin result = shr;                            mq_new = ror; end
      default: begin result = '0;                             wr = 1'b0;    end
    endcase
  end

  assign mq_next = (op_valid && wr) ? mq_new : mq;

  always_ff @(posedge clk) begin
    if (!rst_n) mq <= '0;
    else        mq <= mq_next;
  end
endmodule

// File: rtl/mq_shift_unit_chk.sv
module mq_shift_unit_chk #(
  parameter int W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [3:0]         op_sel,
  input logic [W-1:0]       operand,
  input logic [$clog2(W):0] amount,
  input logic [W-1:0]       result,
  input logic [W-1:0]       mq
);
  localparam int SW = $clog2(W);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> mq == '0); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(mq)); // R2
  AST_SLLQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd2) |=> $stable(mq)); // R6
  AST_BAD_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel > 4'd9) |-> (result == '0)); // R3
  AST_BAD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel > 4'd9) |=> $stable(mq)); // R3
  AST_SRAQ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd4 && amount[SW]) |-> (&result)); // R9
  AST_SLE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd0) |->
      ((result & ~({W{1'b1}} << amount[SW-1:0])) == '0)); // R4
endmodule

bind mq_shift_unit mq_shift_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
  .operand(operand), .amount(amount), .result(result), .mq(mq)
);

// File: tb/sim_mq_shift_unit.sv
module sim_mq_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] operand = '0;
  logic [5:0]  amount = '0;
  logic [31:0] result, mq_next, mq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mq_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .operand(operand), .amount(amount), .result(result),
    .mq_next(mq_next), .mq(mq)
  );

  localparam logic [31:0] M = 32'hCAFEF00D;
  localparam int NV = 20;
  // op, amount, operand, expected result, expected mq_next, writes
  localparam logic [106:0] VEC [NV] = '{
    {4'd0, 6'd4,  32'h12345678, 32'h23456780, 32'h23456781, 1'b1}, // R4
    {4'd1, 6'd4,  32'h12345678, 32'h2345678C, 32'h23456781, 1'b1}, // R5
    {4'd2, 6'd4,  32'h12345678, 32'h2345678D, M,            1'b0}, // R6
    {4'd2, 6'd36, 32'h12345678, 32'hCAFEF000, M,            1'b0}, // R6
    {4'd3, 6'd4,  32'h12345678, 32'h23456780, 32'h23456781, 1'b1}, // R7
    {4'd3, 6'd36, 32'h12345678, 32'h00000001, 32'h23456781, 1'b1}, // R7
    {4'd4, 6'd4,  32'h87654321, 32'hF8765432, 32'h18765432, 1'b1}, // R9
    {4'd4, 6'd36, 32'h12345678, 32'hFFFFFFFF, 32'h81234567, 1'b1}, // R9
    {4'd5, 6'd4,  32'h87654321, 32'hF8765432, 32'h18765432, 1'b1}, // R10
    {4'd6, 6'd4,  32'h87654321, 32'hF8765432, 32'h08765432, 1'b1}, // R11
    {4'd7, 6'd4,  32'h12345678, 32'hC9234567, 32'h81234567, 1'b1}, // R12
    {4'd8, 6'd4,  32'h12345678, 32'h02FEF00D, 32'h81234567, 1'b1}, // R13
    {4'd8, 6'd36, 32'h12345678, 32'hC9234567, 32'h81234567, 1'b1}, // R13
    {4'd9, 6'd4,  32'h12345678, 32'h01234567, 32'h81234567, 1'b1}, // R10
    {4'd9, 6'd0,  32'h87654321, 32'h87654321, 32'h87654321, 1'b1}, // R8
    {4'd1, 6'd0,  32'h12345678, 32'h12345678, 32'h12345678, 1'b1}, // R5
    {4'd7, 6'd0,  32'h12345678, 32'h92345678, 32'h12345678, 1'b1}, // R12
    {4'd5, 6'd31, 32'h80000000, 32'hFFFFFFFF, 32'h00000001, 1'b1}, // R8
    {4'd12,6'd4,  32'h12345678, 32'h00000000, M,            1'b0}, // R3
    {4'd0, 6'd32, 32'h12345678, 32'h12345678, 32'h12345678, 1'b1}  // R4
  };
  localparam string TAG [NV] = '{"R4","R5","R6","R6","R7","R7","R9","R9",
    "R10","R11","R12","R13","R13","R10","R8","R5","R12","R8","R3","R4"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] op, input logic [5:0] am, input logic [31:0] a);
    @(negedge clk);
    op_valid = v; op_sel = op; amount = am; operand = a;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", mq, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, 4'd0, 6'd0, M);
      drive(1'b1, VEC[i][106:103], VEC[i][102:97], VEC[i][96:65]);
      #1;
      check(TAG[i], result, VEC[i][64:33]);
      check(TAG[i], mq_next, VEC[i][32:1]);
      @(posedge clk); #1;
      check("R2", mq, VEC[i][0] ? VEC[i][32:1] : M);
    end

    drive(1'b1, 4'd0, 6'd0, M);
    drive(1'b0, 4'd0, 6'd4, 32'h12345678);
    #1 check("R2", mq_next, M);
    @(posedge clk); #1 check("R2", mq, M);

    drive(1'b1, 4'd6, 6'd0, 32'hDEADBEEF);
    @(posedge clk); #1 check("R11", mq, 32'hDEADBEEF);

    @(negedge clk);
    rst_n = 1'b0; op_valid = 1'b0;
    @(posedge clk); #1 check("R1", mq, 32'h0);
    rst_n = 1'b1;
    finish_run();
  end
endmodule